// File: doc/BRIEF.md
# Pull-up Presence Detector

This block finds out whether an external pull-up resistor holds a bidirectional pin high. On a start pulse it enables the pin driver with a low output value. This discharges the line for a fixed number of clock cycles. It then releases the driver and lets the line float for a second fixed window. At the end of that window it reads the pin through a two-flop synchronizer. A high reading means a resistor pulled the line back up, so the present flag is set. A low reading clears the flag. A one-cycle done pulse marks the moment the flag takes its new value.

A single instance serves several pins one after another. The caller routes the output-enable, the output value and the input through its own pin multiplexer. Typical uses are a memory chip-select line, which tells whether a memory is fitted, and a clock line used as a strap option. The two phase lengths are parameters. At 20 MHz, 20 and 100 cycles give about 1 us of drive and 5 us of settling.

Top module: `pullup_probe`

## Requirements
- R1: Whenever `pin_oe_o` is 1, `pin_out_o` is 0, so the pin is only ever driven low.
- R2: A start accepted at a clock edge raises `pin_oe_o` in the following cycle. It then stays high for exactly `DRIVE_CYC` cycles.
- R3: After the drive phase, `pin_oe_o` stays 0 for exactly `SETTLE_CYC` cycles. `done_o` is then 1 for exactly one cycle, in the cycle right after the last settle cycle.
- R4: `present_o` takes the synchronized pin level at the end of the settle window: 1 for a high line (pull-up present) and 0 for a low line. It changes in the same cycle that `done_o` is 1.
- R5: Between results, `present_o` holds its last value, including for the whole of a new test.
- R6: A start pulse that arrives while a test is running is ignored. The drive and settle timing of the running test is unchanged, and no extra test follows.
- R7: A start pulse in the same cycle as `done_o` is accepted and begins a new test with the timing of R2 and R3.
- R8: During and right after reset, `pin_oe_o`, `done_o` and `present_o` are 0.
- R9: The pin passes through two flops before it is sampled. The result reflects the pin level at the clock edge two edges before the edge at which `done_o` rises. A change after that edge does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a test, taken only when idle |
| pin_in_i | input | 1 | Level read back from the pin under test (asynchronous) |
| pin_oe_o | output | 1 | Driver enable for the pin under test |
| pin_out_o | output | 1 | Driver value for the pin, always low |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| present_o | output | 1 | 1 when the last test found a pull-up |

## Verification
Two events can fall in the same cycle. One is the completion of a test, when `done_o` pulses and `present_o` is written. The other is the acceptance of the next start. The bench raises `start_i` in exactly the cycle where it sees `done_o`. It then checks three things: the new drive phase begins on the next cycle, the fresh result stays stable through the new test, and the following result is sampled at the right edge. Start pulses are also injected at random points inside a running test, and the bench confirms that the drive and settle lengths are unchanged.

// File: rtl/pullup_probe_pkg.sv
package pullup_probe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRIVE  = 2'd1,
    PH_SETTLE = 2'd2
  } probe_phase_e;

  // Width needed to hold the larger phase length minus one.
  function automatic int unsigned phase_cnt_width(input int unsigned drive_len,
                                                  input int unsigned settle_len);
    int unsigned mx;
    mx = (drive_len > settle_len) ? drive_len : settle_len;
    return (mx <= 2) ? 1 : $clog2(mx);
  endfunction

  // Reload value of the down-counter for a phase of the given length.
  function automatic int unsigned phase_reload(input int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

  // Cycles from start acceptance edge to the edge that raises done.
  function automatic int unsigned probe_latency(input int unsigned drive_len,
                                                input int unsigned settle_len);
    return drive_len + settle_len;
  endfunction

endpackage

// File: rtl/pullup_probe_sync.sv
module pullup_probe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pullup_probe_timer.sv
module pullup_probe_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pullup_probe_ctrl.sv
module pullup_probe_ctrl
  import pullup_probe_pkg::*;
#(
  parameter int DRIVE_CYC  = 20,
  parameter int SETTLE_CYC = 100,
  parameter int CW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tmr_zero_i,
  input  logic          pin_sync_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          tmr_run_o,
  output logic          drive_o,
  output logic          busy_o,
  output logic          accept_o,
  output logic          sample_o,
  output logic          done_o,
  output logic          present_o
);
  localparam logic [CW-1:0] DRIVE_RELOAD  = CW'(phase_reload(DRIVE_CYC));
  localparam logic [CW-1:0] SETTLE_RELOAD = CW'(phase_reload(SETTLE_CYC));

  probe_phase_e phase_q, phase_d;
  logic done_q, present_q;
  logic drive_end;

  assign accept_o  = (phase_q == PH_IDLE) && start_i;
  assign drive_end = (phase_q == PH_DRIVE) && tmr_zero_i;
  assign sample_o  = (phase_q == PH_SETTLE) && tmr_zero_i;

  always_comb begin
    phase_d    = phase_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = DRIVE_RELOAD;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d    = PH_DRIVE;
        tmr_load_o = 1'b1;
        tmr_val_o  = DRIVE_RELOAD;
      end
      PH_DRIVE: if (tmr_zero_i) begin
        phase_d    = PH_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = SETTLE_RELOAD;
      end
      PH_SETTLE: if (tmr_zero_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      done_q    <= 1'b0;
      present_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= sample_o;
      if (sample_o) present_q <= pin_sync_i;
    end
  end

  assign tmr_run_o = (phase_q != PH_IDLE);
  assign drive_o   = (phase_q == PH_DRIVE);
  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign present_o = present_q;

  logic unused_drive_end;
  assign unused_drive_end = drive_end;
endmodule

// File: rtl/pullup_probe.sv
module pullup_probe
  import pullup_probe_pkg::*;
#(
  parameter int DRIVE_CYC   = 20,
  parameter int SETTLE_CYC  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pin_in_i,
  output logic pin_oe_o,
  output logic pin_out_o,
  output logic done_o,
  output logic present_o
);
  localparam int CW = phase_cnt_width(DRIVE_CYC, SETTLE_CYC);

  logic          pin_sync;
  logic          tmr_load, tmr_run, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          drive, busy, accept, sample;

  pullup_probe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in_i), .sync_o(pin_sync)
  );

  pullup_probe_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .run_i(tmr_run), .zero_o(tmr_zero)
  );

  pullup_probe_ctrl #(.DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmr_zero_i(tmr_zero),
    .pin_sync_i(pin_sync), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .tmr_run_o(tmr_run), .drive_o(drive), .busy_o(busy), .accept_o(accept),
    .sample_o(sample), .done_o(done_o), .present_o(present_o)
  );

  assign pin_oe_o  = drive;
  assign pin_out_o = 1'b0;
endmodule

// File: rtl/pullup_probe_chk.sv
module pullup_probe_chk #(
  parameter int DRIVE_CYC  = 20,
  parameter int SETTLE_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic pin_oe_o,
  input logic pin_out_o,
  input logic done_o,
  input logic present_o,
  input logic busy,
  input logic accept,
  input logic sample
);
  logic [15:0] oe_run_q, rel_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run_q  <= '0;
      rel_run_q <= '0;
    end else begin
      oe_run_q  <= pin_oe_o ? oe_run_q + 1'b1 : '0;
      rel_run_q <= (busy && !pin_oe_o) ? rel_run_q + 1'b1 : '0;
    end
  end

  always_comb begin
    if (pin_oe_o) AST_DRIVE_ONLY_LOW: assert (pin_out_o == 1'b0); // R1
  end

  AST_DRIVE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_oe_o && $past(pin_oe_o)) |-> (oe_run_q == 16'(DRIVE_CYC))); // R2

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pin_oe_o); // R2

  AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (rel_run_q == 16'(SETTLE_CYC))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3

  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> done_o); // R3

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(present_o)); // R5

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !sample) |=> busy); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy && !pin_oe_o)); // R7
endmodule

bind pullup_probe pullup_probe_chk #(.DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pin_oe_o(pin_oe_o),
  .pin_out_o(pin_out_o), .done_o(done_o), .present_o(present_o),
  .busy(busy), .accept(accept), .sample(sample)
);

// File: tb/sim_pullup_probe.sv
module sim_pullup_probe;
  localparam int D = 20;
  localparam int T = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic pin_drv = 1'b1;
  logic pin_in_i;
  logic pin_oe_o, pin_out_o, done_o, present_o;

  int n_chk = 0;
  int n_bad = 0;
  bit pending = 1'b0;
  bit last_res = 1'b0;

  always #10 clk = ~clk;

  // Pin model: driven low when enabled, otherwise the external level.
  assign pin_in_i = pin_oe_o ? pin_out_o : pin_drv;

  pullup_probe #(.DRIVE_CYC(D), .SETTLE_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pin_in_i(pin_in_i),
    .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o), .done_o(done_o), .present_o(present_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected result: the level seen at edge S0+D+T-2 by the synchronizer.
  function automatic bit expect_result(input bit lvl, input int flip_at, input bit flip_lvl);
    if (flip_at >= 0 && flip_at <= D + T - 3) return flip_lvl;
    return lvl;
  endfunction

  // k counts negedges after the acceptance edge S0.
  task automatic run_test(input bit lvl, input int flip_at, input bit flip_lvl,
                          input int busy_k, input bit chain);
    bit exp;
    exp = expect_result(lvl, flip_at, flip_lvl);
    pin_drv = lvl;
    if (!pending) start_i = 1'b1;
    for (int k = 0; k <= D + T; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (k == 0 || k == D - 1 || k == D || k == D + T - 1 || k == D + T) begin
        check("R2 drive window", pin_oe_o, (k < D));
        check("R3 done timing", done_o, (k == D + T));
      end
      if (pin_oe_o) check("R1 drive value", pin_out_o, 1'b0);
      if (k == D) check("R5 result held", present_o, last_res);
      if (k == busy_k) start_i = 1'b1;          // R6 start while busy
      if (k == flip_at) pin_drv = flip_lvl;
    end
    check("R4 present value", present_o, exp);
    last_res = exp;
    if (chain) begin
      start_i = 1'b1;                           // R7 start with done
      pending = 1'b1;
    end else begin
      pending = 1'b0;
      @(negedge clk);
      check("R3 done one cycle", done_o, 1'b0);
      check("R6 no extra test", pin_oe_o, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R8 reset oe", pin_oe_o, 1'b0);
    check("R8 reset done", done_o, 1'b0);
    check("R8 reset present", present_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle present", present_o, 1'b0);

    run_test(1'b1, -1, 1'b0, -1, 1'b0);          // R4 pull-up present
    run_test(1'b0, -1, 1'b0, -1, 1'b0);          // R4 no pull-up
    run_test(1'b1, -1, 1'b0, 5, 1'b0);           // R6 start during drive
    run_test(1'b0, -1, 1'b0, D + 10, 1'b0);      // R6 start during settle
    run_test(1'b1, D + T - 3, 1'b0, -1, 1'b0);   // R9 last counted edge
    run_test(1'b1, D + T - 2, 1'b0, -1, 1'b0);   // R9 too late to count
    run_test(1'b0, D + T - 3, 1'b1, -1, 1'b1);   // R9 and R7 chain
    run_test(1'b0, -1, 1'b0, -1, 1'b1);          // R7 back to back
    run_test(1'b1, -1, 1'b0, -1, 1'b0);

    for (int i = 0; i < 25; i++) begin
      bit lvl, fl, ch;
      int fa, bk;
      lvl = 1'($urandom_range(0, 1));
      fl  = 1'($urandom_range(0, 1));
      fa  = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, D + T - 1));
      bk  = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(1, D + T - 1));
      ch  = (i != 24) && ($urandom_range(0, 3) == 0);
      run_test(lvl, fa, fl, bk, ch);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule